// File: doc/BRIEF.md
# Three-Phase Voltage Sag Detector

This block watches the sample streams of three phase voltages and reports, for each phase, whether that phase is in a sag. It works in half-line cycles. A per-phase strobe marks the end of each half cycle. The block takes the largest absolute sample seen during that half cycle and compares it with a programmable unsigned threshold. A phase enters the sag state after its half-cycle peak has stayed under the threshold for a programmed number of consecutive half cycles. It leaves the sag state after the peak has stayed at or above the threshold for the same number of half cycles.

Every change of any phase state, into a sag or out of it, sets one sticky event flag. That flag drives an active-low interrupt pin through a mask bit. Host software clears the flag by writing a one to it. A small write port loads the threshold, the half-cycle count, the flag-clear and the mask. Each phase keeps its own run counter. A write to the half-cycle count restarts all three counters, so the next decision is based on a full run.

Top module: `vsag_monitor`

## Requirements
- R1: After reset, phase_state is 3'b000, sag_flag is 0 and irq_n is 1.
- R2: A half cycle counts as "low" when the largest absolute value of the two's-complement samples in it, up to and including the sample on the strobe cycle, is strictly less than the threshold. The threshold is loaded by a write with wr_sel=0 from wr_data[23:0]. A sample equal to the threshold is not low. A single high sample makes the whole half cycle high.
- R3: A phase's state bit becomes 1 after N consecutive low half cycles and becomes 0 after N consecutive non-low half cycles, where N is the half-cycle count. Any half cycle that agrees with the current state restarts that phase's run. Phase A is bit 0, phase B is bit 1 and phase C is bit 2 of phase_state. The phases are independent.
- R4: Every change of any phase_state bit sets sag_flag on the same clock edge. The flag stays set until it is cleared.
- R5: A write with wr_sel=2 and wr_data[16]=1 clears sag_flag. The same write with wr_data[16]=0 leaves sag_flag unchanged.
- R6: If a state change and a clear write happen on the same edge, sag_flag ends up set.
- R7: The mask is loaded by a write with wr_sel=3 from wr_data[16]. irq_n is low exactly when sag_flag and the mask bit are both 1, and it changes on the same edge as either of them.
- R8: The half-cycle count is loaded by a write with wr_sel=1 from wr_data[7:0]. A count of 0 behaves as 1.
- R9: A write to the half-cycle count discards any partial run on every phase. A write to the threshold does not discard partial runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_a | input | SMP_W | Phase A sample, two's complement |
| smp_b | input | SMP_W | Phase B sample, two's complement |
| smp_c | input | SMP_W | Phase C sample, two's complement |
| zc | input | 3 | Per-phase end-of-half-cycle strobe (bit 0 = A) |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select: 0 threshold, 1 count, 2 flag clear, 3 mask |
| wr_data | input | 32 | Write data |
| phase_state | output | 3 | Per-phase sag state |
| sag_flag | output | 1 | Sticky state-change flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Three situations are hard to reach from the ports. The first is a state change that lands on the exact edge of a host clear. The bench raises the clear write in the same cycle as the strobe that completes a run. The second is a partial run that a count write should discard while a threshold write should not. The bench stops two half cycles into a three-cycle run, writes one register or the other, and then counts how many more half cycles it takes to change state. Peak handling is covered by half cycles that sit exactly on the threshold and by half cycles that are low apart from one spike sample.

// File: rtl/vsag_pkg.sv
package vsag_pkg;

  typedef enum logic [1:0] {
    SEL_THRESH = 2'd0,
    SEL_HCYC   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_MASK   = 2'd3
  } vsag_sel_e;

  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned FLAG_BIT   = 16;
  localparam int unsigned WDATA_W    = 32;

endpackage

// File: rtl/vsag_peak.sv
module vsag_peak #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned THR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SMP_W-1:0] smp,
  input  logic                    zc,
  input  logic [THR_W-1:0]        thresh,
  output logic                    below
);

  localparam int unsigned CMP_W = (SMP_W > THR_W) ? SMP_W : THR_W;

  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] peak_q;
  logic [SMP_W-1:0] peak_now;

  // Two's-complement magnitude; the most negative code maps onto 2^(SMP_W-1).
  always_comb begin
    mag      = smp[SMP_W-1] ? (~smp + 1'b1) : smp;
    peak_now = (mag > peak_q) ? mag : peak_q;
    below    = (CMP_W'(peak_now) < CMP_W'(thresh));
  end

  always_ff @(posedge clk) begin
    if (rst || zc) begin
      peak_q <= '0;
    end else begin
      peak_q <= peak_now;
    end
  end

  // R2: each half cycle starts with an empty peak.
  assert_peak_restart_R2: assert property (@(posedge clk) disable iff (rst)
    $past(zc) |-> (peak_q == '0));

endmodule

// File: rtl/vsag_debounce.sv
module vsag_debounce #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc,
  input  logic             below,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  output logic             state,
  output logic             flip
);

  logic [CNT_W-1:0] run_q, run_d;
  logic             state_d;
  logic [CNT_W:0]   run_inc;

  always_comb begin
    run_inc = {1'b0, run_q} + 1'b1;
    run_d   = run_q;
    state_d = state;
    flip    = 1'b0;
    if (restart) begin
      run_d = '0;
    end else if (zc) begin
      if (below != state) begin
        if (run_inc >= {1'b0, limit}) begin
          flip    = 1'b1;
          state_d = ~state;
          run_d   = '0;
        end else begin
          run_d = run_inc[CNT_W-1:0];
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      state <= 1'b0;
    end else begin
      run_q <= run_d;
      state <= state_d;
    end
  end

  // R3: the state moves only on a half-cycle boundary.
  assert_state_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> $past(zc));

  // R3: a partial run never reaches the programmed length.
  assert_run_below_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q < limit));

  // R9: a count write leaves no partial run behind.
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (run_q == '0));

endmodule

// File: rtl/vsag_event.sv
module vsag_event #(
  parameter int unsigned FLAG_POS = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              flag,
  output logic              irq_n
);

  logic mask_q;
  logic flag_d, mask_d;

  always_comb begin
    mask_d = mask_wr ? wr_data[FLAG_POS] : mask_q;
    flag_d = flag;
    if (clr_wr && wr_data[FLAG_POS]) flag_d = 1'b0;
    if (evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      mask_q <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      flag   <= flag_d;
      mask_q <= mask_d;
      irq_n  <= ~(flag_d & mask_d);
    end
  end

  // R4, R6: an event always leaves the flag set.
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag);

  // R5: a clear with no event takes the flag down.
  assert_clear_works_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && wr_data[FLAG_POS] && !evt) |=> !flag);

  // R7: an unmasked rise of the flag pulls the pin low in the same cycle.
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag) && mask_q) |-> !irq_n);

endmodule

// File: rtl/vsag_monitor.sv
module vsag_monitor
  import vsag_pkg::*;
#(
  parameter int unsigned SMP_W  = 24,
  parameter int unsigned THR_W  = 24,
  parameter int unsigned HCYC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SMP_W-1:0] smp_a,
  input  logic signed [SMP_W-1:0] smp_b,
  input  logic signed [SMP_W-1:0] smp_c,
  input  logic [2:0]              zc,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [WDATA_W-1:0]      wr_data,
  output logic [2:0]              phase_state,
  output logic                    sag_flag,
  output logic                    irq_n
);

  logic [THR_W-1:0]  thresh_q;
  logic [HCYC_W-1:0] hcyc_q;
  logic [HCYC_W-1:0] limit;
  logic              hcyc_wr, status_wr, mask_wr;
  logic signed [SMP_W-1:0] smp [NUM_PHASES];
  logic [NUM_PHASES-1:0] below, flip;
  logic              unused_wdata;

  assign unused_wdata = ^wr_data;
  assign smp[0] = smp_a;
  assign smp[1] = smp_b;
  assign smp[2] = smp_c;

  always_comb begin
    hcyc_wr   = wr_en && (vsag_sel_e'(wr_sel) == SEL_HCYC);
    status_wr = wr_en && (vsag_sel_e'(wr_sel) == SEL_STATUS);
    mask_wr   = wr_en && (vsag_sel_e'(wr_sel) == SEL_MASK);
    limit     = (hcyc_q == '0) ? HCYC_W'(1) : hcyc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_q <= '0;
      hcyc_q   <= '0;
    end else if (wr_en) begin
      if (vsag_sel_e'(wr_sel) == SEL_THRESH) thresh_q <= wr_data[THR_W-1:0];
      if (hcyc_wr) hcyc_q <= wr_data[HCYC_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    vsag_peak #(.SMP_W(SMP_W), .THR_W(THR_W)) i_peak (
      .clk    (clk),
      .rst    (rst),
      .smp    (smp[p]),
      .zc     (zc[p]),
      .thresh (thresh_q),
      .below  (below[p])
    );

    vsag_debounce #(.CNT_W(HCYC_W)) i_deb (
      .clk     (clk),
      .rst     (rst),
      .zc      (zc[p]),
      .below   (below[p]),
      .limit   (limit),
      .restart (hcyc_wr),
      .state   (phase_state[p]),
      .flip    (flip[p])
    );
  end

  vsag_event #(.FLAG_POS(FLAG_BIT), .DATA_W(WDATA_W)) i_event (
    .clk     (clk),
    .rst     (rst),
    .evt     (|flip),
    .clr_wr  (status_wr),
    .mask_wr (mask_wr),
    .wr_data (wr_data),
    .flag    (sag_flag),
    .irq_n   (irq_n)
  );

  // R4: the flag rises only on an edge that moved a phase state.
  assert_flag_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sag_flag) |-> (phase_state != $past(phase_state)));

  // R4: every state change leaves the flag set.
  assert_change_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_state != $past(phase_state)) |-> sag_flag);

endmodule

// File: tb/test_vsag_monitor.sv
module test_vsag_monitor;

  localparam int LO = 500;
  localparam int HI = 2000;
  // {low mask[2:0], expected state[2:0], expected flag, clear after}
  localparam logic [7:0] VEC [12] = '{
    8'b001_000_0_0, 8'b001_001_1_1, 8'b011_001_0_0, 8'b001_001_0_0,
    8'b111_001_0_0, 8'b111_111_1_0, 8'b110_111_1_1, 8'b111_111_0_0,
    8'b110_111_0_0, 8'b110_110_1_1, 8'b000_110_0_0, 8'b000_000_1_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [23:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic [2:0]  zc = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  phase_state;
  logic        sag_flag, irq_n;
  logic        pol = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsag_monitor i_vsag_monitor (
    .clk(clk), .rst(rst), .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
    .zc(zc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .phase_state(phase_state), .sag_flag(sag_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Three samples per half cycle, strobe on the last, sign alternating.
  task automatic half_cycle(input int aa, input int ab, input int ac,
                            input bit spike, input bit clr_same);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      smp_a = pol ? -aa : aa;
      smp_b = pol ? -ab : ab;
      smp_c = pol ? -ac : ac;
      if (spike && i == 1) begin
        smp_a = pol ? -HI : HI; smp_b = pol ? -HI : HI; smp_c = pol ? -HI : HI;
      end
      zc = (i == 2) ? 3'b111 : 3'b000;
      if (i == 2 && clr_same) begin
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0001_0000;
      end
    end
    @(negedge clk);
    zc = '0; wr_en = 1'b0; wr_data = '0;
    smp_a = '0; smp_b = '0; smp_c = '0;
    pol = ~pol;
  endtask

  task automatic hc_mask(input logic [2:0] low);
    half_cycle(low[0] ? LO : HI, low[1] ? LO : HI, low[2] ? LO : HI, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 state", phase_state, 0);
    check("R1 flag", sag_flag, 0);
    check("R1 irq_n", irq_n, 1);

    wr(2'd0, 32'd1000);
    wr(2'd1, 32'd2);
    wr(2'd3, 32'h0001_0000);

    // Table walk: R3 sequences, R4 flagging, R5 clears, R7 pin.
    foreach (VEC[k]) begin
      hc_mask(VEC[k][7:5]);
      check($sformatf("R3 state vec %0d", k), phase_state, VEC[k][4:2]);
      check($sformatf("R4 flag vec %0d", k), sag_flag, VEC[k][1]);
      check($sformatf("R7 irq vec %0d", k), irq_n, !VEC[k][1]);
      if (VEC[k][0]) begin
        wr(2'd2, 32'h0001_0000);
        check($sformatf("R5 clear vec %0d", k), sag_flag, 0);
        check($sformatf("R7 release vec %0d", k), irq_n, 1);
      end
    end

    // R5: writing 0 at bit 16 keeps the flag.
    hc_mask(3'b001); hc_mask(3'b001);
    check("R3 A set", phase_state, 3'b001);
    wr(2'd2, 32'hFFFE_FFFF);
    check("R5 zero write keeps", sag_flag, 1);
    wr(2'd2, 32'h0001_0000);
    check("R5 one write clears", sag_flag, 0);

    // R6: event and clear on the same edge.
    hc_mask(3'b000);
    half_cycle(HI, HI, HI, 1'b0, 1'b1);
    check("R6 state", phase_state, 3'b000);
    check("R6 set wins", sag_flag, 1);
    wr(2'd2, 32'h0001_0000);

    // R7: masked event leaves pin high; unmasking pulls it low.
    wr(2'd3, 32'h0);
    hc_mask(3'b001); hc_mask(3'b001);
    check("R7 masked flag", sag_flag, 1);
    check("R7 masked pin", irq_n, 1);
    wr(2'd3, 32'h0001_0000);
    check("R7 unmask pin", irq_n, 0);
    wr(2'd2, 32'h0001_0000);
    check("R7 cleared pin", irq_n, 1);

    // R2: a peak equal to the threshold is not low; one below is.
    half_cycle(LO, 1000, HI, 1'b0, 1'b0);
    half_cycle(LO, 1000, HI, 1'b0, 1'b0);
    check("R2 equal not low", phase_state, 3'b001);
    half_cycle(999, 999, HI, 1'b0, 1'b0);
    half_cycle(999, 999, HI, 1'b0, 1'b0);
    check("R2 below threshold", phase_state, 3'b011);
    wr(2'd2, 32'h0001_0000);

    // R2: a single spike makes a half cycle high.
    half_cycle(LO, LO, HI, 1'b1, 1'b0);
    half_cycle(LO, LO, HI, 1'b1, 1'b0);
    check("R2 spike counts high", phase_state, 3'b000);
    wr(2'd2, 32'h0001_0000);

    // R8: a count of 0 acts as 1.
    wr(2'd1, 32'd0);
    hc_mask(3'b100);
    check("R8 zero count set", phase_state, 3'b100);
    hc_mask(3'b000);
    check("R8 zero count clear", phase_state, 3'b000);
    wr(2'd2, 32'h0001_0000);

    // R9: count write discards a partial run, threshold write does not.
    wr(2'd1, 32'd3);
    hc_mask(3'b100); hc_mask(3'b100);
    wr(2'd1, 32'd3);
    hc_mask(3'b100); hc_mask(3'b100);
    check("R9 restart holds", phase_state, 3'b000);
    hc_mask(3'b100);
    check("R9 full run after restart", phase_state, 3'b100);
    wr(2'd2, 32'h0001_0000);
    hc_mask(3'b000); hc_mask(3'b000);
    wr(2'd0, 32'd1000);
    hc_mask(3'b000);
    check("R9 threshold keeps run", phase_state, 3'b000);
    check("R4 flag on clear-direction", sag_flag, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule